// File: doc/BRIEF.md
# Host Launch and Blocking-Result Mailbox

This block is the register face that an in-memory processor presents to a host. The processor can never drive the host bus on its own. The host therefore starts it by writing a command argument into a launch register. It then learns the outcome either by polling a status word or by reading a result word. The block turns the launch write into a one-cycle start pulse towards the processor, with the argument held steady. It tracks the job until the processor reports completion or a cycle limit runs out.

A result read that arrives while the job is still running is not refused. The block keeps the read pending and re-examines the job state every `RETRY_GAP` cycles. It answers only once the job has ended. The host sees one read with a long latency and never learns that any retries took place. If the processor never finishes, a timeout ends the job with a fill value, so a pending read cannot hang forever.

The register map is `req_addr` 0 for launch (write), 1 for status (read, write-1-to-clear), 2 for result (read), and 3 unused.

Top module: `pim_host_mailbox`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `core_start` are 0, and a status read returns 0.
- R2: A write to address 0 while no job is in progress drives `core_start` high for exactly one cycle, the cycle after acceptance. `core_arg` then equals the written data and holds it while the job runs. The busy status bit is set from the start cycle on.
- R3: Every accepted request other than a result read during a job gets exactly one `rsp_valid` pulse in the cycle after acceptance. Write responses carry 0.
- R4: The status word has bit 0 = busy, bit 1 = done, bit 2 = rejected-launch error and bit 3 = timeout error. All other bits read 0.
- R5: A `core_done` pulse during a job ends it. It clears busy, sets done and captures `core_result` as the result.
- R6: A result read with no job in progress is answered in the next cycle with the captured result, and it clears the done bit.
- R7: A result read during a job gives no response and holds `req_ready` low until the job ends. It is then answered with the captured result no later than `RETRY_GAP`+2 cycles after the `core_done` pulse.
- R8: A write to address 0 while a job is in progress produces no start pulse and leaves `core_arg` unchanged. It sets status bit 2.
- R9: Writing the status address clears bit 2 and/or bit 3 where the written data has a 1 in that position. Zero bits leave the flags as they are.
- R10: A job still busy after `TIMEOUT_LIMIT` busy cycles ends without done. Status bit 3 is set, and the result becomes `FILL_VALUE` (default 0xDEADBEEF), which is returned to any pending result read.
- R11: Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Response data |
| core_start | output | 1 | Launch pulse to the processor |
| core_arg | output | DATA_W | Command argument |
| core_done | input | 1 | Completion pulse from the processor |
| core_result | input | DATA_W | Result captured on completion |

## Verification
The bench holds a result read open across a long job. A design that leaked a retry would show an early `rsp_valid`, and one that dropped the read would never answer. A launch is sent while a job runs: a faulty design would pulse `core_start` again or overwrite `core_arg`. Status writes with zero bits check that the error flags are write-1-to-clear rather than plain writes. A job that never completes checks that the pending read is released with the fill value and the timeout flag, instead of hanging or returning stale data.

// File: rtl/pim_mb_pkg.sv
package pim_mb_pkg;

  localparam logic [1:0] ADR_LAUNCH = 2'd0;
  localparam logic [1:0] ADR_STATUS = 2'd1;
  localparam logic [1:0] ADR_RESULT = 2'd2;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_REJ  = 2;
  localparam int ST_TMO  = 3;

  typedef enum logic {HP_IDLE = 1'b0, HP_HOLD = 1'b1} hp_state_e;

  // Assemble the four status flags into their bit positions.
  function automatic logic [3:0] pack_status(input logic busy, input logic done,
                                             input logic rej, input logic tmo);
    logic [3:0] s;
    s = '0;
    s[ST_BUSY] = busy;
    s[ST_DONE] = done;
    s[ST_REJ]  = rej;
    s[ST_TMO]  = tmo;
    return s;
  endfunction

  // Sticky flag update: a set event wins over a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

  // Down-counter step that reloads after reaching zero.
  function automatic int unsigned gap_step(input int unsigned cur, input int unsigned gap);
    return (cur == 0) ? gap - 1 : cur - 1;
  endfunction

endpackage

// File: rtl/mb_retry.sv
module mb_retry #(
  parameter int RETRY_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic probe
);
  import pim_mb_pkg::*;

  localparam int CW = (RETRY_GAP < 2) ? 1 : $clog2(RETRY_GAP);
  localparam logic [CW-1:0] RELOAD = CW'(RETRY_GAP - 1);

  logic [CW-1:0] cnt_q;

  assign probe = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= RELOAD;
    end else if (run) begin
      cnt_q <= CW'(gap_step(int'(cnt_q), RETRY_GAP));
    end
  end

endmodule

// File: rtl/mb_launch.sv
module mb_launch #(
  parameter int          DATA_W        = 32,
  parameter int          TIMEOUT_LIMIT = 1000,
  parameter logic [31:0] FILL_VALUE    = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_req,
  input  logic [DATA_W-1:0] launch_arg,
  input  logic              clear_done,
  input  logic              core_done,
  input  logic [DATA_W-1:0] core_result,
  output logic              core_start,
  output logic [DATA_W-1:0] core_arg,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              engaged,
  output logic              done_hit,
  output logic              tmo_hit
);

  localparam int TW = $clog2(TIMEOUT_LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_LIMIT - 1);

  logic              start_q, busy_q, done_q;
  logic [DATA_W-1:0] arg_q, result_q;
  logic [TW-1:0]     tmo_cnt_q;

  assign core_start = start_q;
  assign core_arg   = arg_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign result     = result_q;
  assign engaged    = start_q | busy_q;
  assign done_hit   = busy_q & core_done;
  assign tmo_hit    = busy_q & ~core_done & (tmo_cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      arg_q     <= '0;
      result_q  <= '0;
      tmo_cnt_q <= '0;
    end else begin
      start_q <= launch_req;
      if (launch_req) begin
        arg_q  <= launch_arg;
        done_q <= 1'b0;
      end
      if (start_q) begin
        busy_q    <= 1'b1;
        tmo_cnt_q <= '0;
      end else if (done_hit) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        result_q <= core_result;
      end else if (tmo_hit) begin
        busy_q   <= 1'b0;
        result_q <= DATA_W'(FILL_VALUE);
      end else if (busy_q) begin
        tmo_cnt_q <= tmo_cnt_q + 1'b1;
      end
      if (clear_done) begin
        done_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mb_host_port.sv
module mb_host_port #(
  parameter int DATA_W    = 32,
  parameter int RETRY_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              engaged,
  input  logic              done,
  input  logic [DATA_W-1:0] result,
  input  logic              tmo_hit,
  output logic              launch_req,
  output logic              clear_done,
  output logic              waiting
);
  import pim_mb_pkg::*;

  hp_state_e         state_q;
  logic              rej_q, tmo_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              accept, is_rd, is_wr;
  logic              rd_result_now, rd_result_hold, probe, release_hold;
  logic              rej_ev, clr_rej, clr_tmo;
  logic [3:0]        status;

  assign req_ready = (state_q == HP_IDLE);
  assign accept    = req_valid & req_ready;
  assign is_wr     = accept & req_write;
  assign is_rd     = accept & ~req_write;
  assign waiting   = (state_q == HP_HOLD);

  assign rd_result_now  = is_rd & (req_addr == ADR_RESULT) & ~engaged;
  assign rd_result_hold = is_rd & (req_addr == ADR_RESULT) & engaged;
  assign release_hold   = waiting & probe & ~engaged;

  assign launch_req = is_wr & (req_addr == ADR_LAUNCH) & ~engaged;
  assign rej_ev     = is_wr & (req_addr == ADR_LAUNCH) & engaged;
  assign clr_rej    = is_wr & (req_addr == ADR_STATUS) & req_wdata[ST_REJ];
  assign clr_tmo    = is_wr & (req_addr == ADR_STATUS) & req_wdata[ST_TMO];
  assign clear_done = rd_result_now | release_hold;

  assign status = pack_status(engaged, done, rej_q, tmo_q);

  mb_retry #(.RETRY_GAP(RETRY_GAP)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (rd_result_hold),
    .run   (waiting),
    .probe (probe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= HP_IDLE;
      rej_q       <= 1'b0;
      tmo_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rej_q       <= sticky_next(rej_q, rej_ev, clr_rej);
      tmo_q       <= sticky_next(tmo_q, tmo_hit, clr_tmo);
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      if (state_q == HP_IDLE) begin
        if (rd_result_hold) begin
          state_q <= HP_HOLD;
        end else if (accept) begin
          rsp_valid_q <= 1'b1;
          if (is_rd && req_addr == ADR_STATUS) begin
            rsp_data_q <= DATA_W'(status);
          end else if (rd_result_now) begin
            rsp_data_q <= result;
          end
        end
      end else if (release_hold) begin
        state_q     <= HP_IDLE;
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= result;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

endmodule

// File: rtl/pim_host_mailbox.sv
module pim_host_mailbox #(
  parameter int          DATA_W        = 32,
  parameter int          RETRY_GAP     = 4,
  parameter int          TIMEOUT_LIMIT = 1000,
  parameter logic [31:0] FILL_VALUE    = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              core_start,
  output logic [DATA_W-1:0] core_arg,
  input  logic              core_done,
  input  logic [DATA_W-1:0] core_result
);

  // Named internal events, visible to the bound checker.
  logic              launch_w, clear_done_w, waiting_w;
  logic              busy_w, done_w, engaged_w, done_hit_w, tmo_hit_w;
  logic [DATA_W-1:0] result_w;

  mb_launch #(
    .DATA_W        (DATA_W),
    .TIMEOUT_LIMIT (TIMEOUT_LIMIT),
    .FILL_VALUE    (FILL_VALUE)
  ) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_req  (launch_w),
    .launch_arg  (req_wdata),
    .clear_done  (clear_done_w),
    .core_done   (core_done),
    .core_result (core_result),
    .core_start  (core_start),
    .core_arg    (core_arg),
    .busy        (busy_w),
    .done        (done_w),
    .result      (result_w),
    .engaged     (engaged_w),
    .done_hit    (done_hit_w),
    .tmo_hit     (tmo_hit_w)
  );

  mb_host_port #(
    .DATA_W    (DATA_W),
    .RETRY_GAP (RETRY_GAP)
  ) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .engaged    (engaged_w),
    .done       (done_w),
    .result     (result_w),
    .tmo_hit    (tmo_hit_w),
    .launch_req (launch_w),
    .clear_done (clear_done_w),
    .waiting    (waiting_w)
  );

endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_addr,
  input logic              rsp_valid,
  input logic              core_start,
  input logic [DATA_W-1:0] core_arg,
  input logic              busy_w,
  input logic              engaged_w,
  input logic              waiting_w,
  input logic              done_hit_w,
  input logic              tmo_hit_w
);

  logic acc, acc_plain, acc_launch_busy;
  assign acc             = req_valid && req_ready;
  assign acc_plain       = acc && !(!req_write && req_addr == 2'd2 && engaged_w);
  assign acc_launch_busy = acc && req_write && req_addr == 2'd0 && engaged_w;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);  // R2
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> busy_w);  // R2
  AST_ARG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> $stable(core_arg));  // R2
  AST_PROMPT_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_plain |=> rsp_valid);  // R3
  AST_HIDDEN_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_w |-> (!rsp_valid && !req_ready));  // R7
  AST_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_launch_busy |=> !core_start);  // R8
  AST_DONE_ENDS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit_w |=> !busy_w);  // R5
  AST_TIMEOUT_ENDS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit_w |=> !busy_w);  // R10

endmodule

bind pim_host_mailbox mb_checker #(.DATA_W(DATA_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .core_start (core_start),
  .core_arg   (core_arg),
  .busy_w     (busy_w),
  .engaged_w  (engaged_w),
  .waiting_w  (waiting_w),
  .done_hit_w (done_hit_w),
  .tmo_hit_w  (tmo_hit_w)
);

// File: tb/tb_pim_host_mailbox.sv
module tb_pim_host_mailbox;
  localparam int GAP   = 3;
  localparam int LIMIT = 40;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, core_start;
  logic [31:0] rsp_rdata, core_arg;
  logic core_done = 1'b0;
  logic [31:0] core_result = '0;

  int errors = 0, checks = 0, starts = 0, cycles = 0;

  always #5 clk = ~clk;

  pim_host_mailbox #(.DATA_W(32), .RETRY_GAP(GAP), .TIMEOUT_LIMIT(LIMIT),
                     .FILL_VALUE(FILL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_start(core_start),
    .core_arg(core_arg), .core_done(core_done), .core_result(core_result));

  always @(posedge clk) begin
    if (core_start) starts++;
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      output logic [31:0] q, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    q = rsp_rdata;
  endtask

  task automatic pulse_done(input logic [31:0] r);
    core_done = 1'b1; core_result = r;
    @(negedge clk);
    core_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] q; int lat;
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 core_start", 32'(core_start), 0);
    xfer(0, 2'd1, 0, q, lat);
    check("R1 status", q, 0);
    check("R3 status latency", lat, 1);
  endtask

  task automatic t_launch_and_reject;
    logic [31:0] q; int lat, s0;
    s0 = starts;
    xfer(1, 2'd0, 32'hA5A5_0001, q, lat);
    check("R3 write latency", lat, 1);
    check("R3 write data", q, 0);
    @(negedge clk);
    check("R2 one start pulse", starts - s0, 1);
    check("R2 arg", core_arg, 32'hA5A5_0001);
    xfer(0, 2'd1, 0, q, lat);
    check("R4 busy bit", q, 32'h1);
    xfer(1, 2'd0, 32'h0000_BBBB, q, lat);
    @(negedge clk);
    check("R8 no second start", starts - s0, 1);
    check("R8 arg kept", core_arg, 32'hA5A5_0001);
    xfer(1, 2'd1, 32'h0, q, lat);
    xfer(0, 2'd1, 0, q, lat);
    check("R8 R9 error set and zero write keeps it", q, 32'h5);
  endtask

  task automatic t_done_and_read;
    logic [31:0] q; int lat;
    @(negedge clk);
    pulse_done(32'h1234_5678);
    xfer(0, 2'd1, 0, q, lat);
    check("R5 done set busy clear", q, 32'h6);
    xfer(1, 2'd1, 32'h4, q, lat);
    xfer(0, 2'd1, 0, q, lat);
    check("R9 clear error bit", q, 32'h2);
    xfer(0, 2'd2, 0, q, lat);
    check("R6 result value", q, 32'h1234_5678);
    check("R6 result latency", lat, 1);
    xfer(0, 2'd1, 0, q, lat);
    check("R6 done cleared", q, 0);
  endtask

  task automatic t_spare;
    logic [31:0] q; int lat;
    xfer(1, 2'd3, 32'hFFFF_FFFF, q, lat);
    check("R11 spare write response", lat, 1);
    xfer(0, 2'd3, 0, q, lat);
    check("R11 spare reads 0", q, 0);
    xfer(0, 2'd1, 0, q, lat);
    check("R11 status untouched", q, 0);
  endtask

  task automatic t_blocking_read;
    logic [31:0] q; int lat;
    xfer(1, 2'd0, 32'h0000_0777, q, lat);
    fork
      xfer(0, 2'd2, 0, q, lat);
      begin
        @(negedge clk);
        repeat (5) @(negedge clk);
        check("R7 ready low while held", 32'(req_ready), 0);
        check("R7 no response while held", 32'(rsp_valid), 0);
        repeat (5) @(negedge clk);
        pulse_done(32'hCAFE_0042);
      end
    join
    checks++;
    if (lat <= 11 || lat > 11 + GAP + 2) begin
      errors++;
      $display("FAIL R7 held latency: actual=%0d expected 12..%0d", lat, 13 + GAP);
    end
    check("R7 held read value", q, 32'hCAFE_0042);
    xfer(0, 2'd1, 0, q, lat);
    check("R7 done cleared by held read", q, 0);
  endtask

  task automatic t_timeout;
    logic [31:0] q; int lat;
    xfer(1, 2'd0, 32'h0000_0999, q, lat);
    xfer(0, 2'd2, 0, q, lat);
    check("R10 fill value returned", q, FILL);
    checks++;
    if (lat < LIMIT - 5 || lat > LIMIT + GAP + 5) begin
      errors++;
      $display("FAIL R10 timeout latency: actual=%0d expected near %0d", lat, LIMIT);
    end
    xfer(0, 2'd1, 0, q, lat);
    check("R10 timeout flag only", q, 32'h8);
    xfer(1, 2'd1, 32'h8, q, lat);
    xfer(0, 2'd1, 0, q, lat);
    check("R9 timeout flag cleared", q, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_launch_and_reject();
    t_done_and_read();
    t_spare();
    t_blocking_read();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule